// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single read and write cycles on an external memory bus for a processor that can own that bus. A requester presents a direction, an address and write data, and holds a request level high. The block then drives an active-low read or write strobe for the length of the access. It captures read data on the last clock of the access and reports completion with a one-clock done pulse.

The length of every access is set by two things. A programmed minimum wait-state count gives a floor. A transfer-acknowledge input can stretch the access without limit for as long as it stays low. The access lasts for whichever of the two is longer. When the minimum count is zero, the access takes its shortest form and the acknowledge input has no effect. A mode input chooses how the acknowledge is taken. It is either used as it arrives, for a source clocked with the block, or passed through a two-flop synchroniser for a source that is not.

The pads are not modelled. Instead, the block has separate output enables for the address lines, the data lines and the strobes. All of them are low while the block does not own the bus and while it is in reset.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: While reset is asserted, addr_oe_o, data_oe_o and strobe_oe_o are 0 and both strobes are 1.
- R2: While master_i is 0, all three output enables are 0 and no access starts. A request held during that time starts its access (strobe low) in the first clock after master_i rises.
- R3: A read (we_i=0) drives rd_n_o low and keeps wr_n_o high. A write (we_i=1) drives wr_n_o low and keeps rd_n_o high. data_oe_o is 1 during the strobe of a write and 0 during the strobe of a read. wdata_o carries the request's write data.
- R4: With min_wait_i=0, the strobe is low for exactly 2 clocks, whatever ack_i does.
- R5: With min_wait_i=N≥1 and ack_async_i=0, the strobe is low for 2+max(N, A−1) clocks. Here ack_i first reads 1 in the A-th clock of the strobe and stays 1 after that (A=0: ack_i is 1 throughout).
- R6: With min_wait_i=N≥1 and ack_async_i=1, the two-flop synchroniser delays acknowledge by two clocks. The strobe is low for 2+N clocks when A=0, and for 2+max(N, A+1) clocks when A≥1.
- R7: done_o is 1 for exactly one clock, the first clock after the strobe returns high. For a read, rdata_o then holds the value of rdata_i at the final strobe clock.
- R8: With no request, ack_i held at 1 starts no access and causes no done pulse.
- R9: During an access, addr_o equals the request's address and addr_oe_o is 1.
- R10: With the request held continuously, the strobes stay high for exactly 2 clocks between consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request level, held until the access starts |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Request write data |
| min_wait_i | input | WAIT_W | Minimum wait states for each access |
| master_i | input | 1 | 1 when this block owns the bus |
| ack_i | input | 1 | Transfer acknowledge, active high |
| ack_async_i | input | 1 | 1 = synchronise ack_i through two flops |
| rdata_i | input | DATA_W | Data returned by the bus |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_o | output | ADDR_W | Address driven onto the bus |
| wdata_o | output | DATA_W | Write data driven onto the bus |
| addr_oe_o | output | 1 | Address driver enable |
| data_oe_o | output | 1 | Data driver enable |
| strobe_oe_o | output | 1 | Strobe driver enable |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=8, WAIT_W=3 and two synchroniser stages. This small size lets it sweep every minimum wait count from 0 to 5 against every acknowledge arrival clock from 0 to 7, in both acknowledge modes and both directions. For each access, the bench predicts the strobe length from the max formulas alone. The sweep reaches the points where the programmed floor and the acknowledge exchange control, in both directions. It also covers the zero-wait case, where a late acknowledge must change nothing.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ASSERT = 2'd1,
      ST_WAIT   = 2'd2,
      ST_FINISH = 2'd3
   } ebus_state_t;
endpackage

// File: rtl/ebus_ack_sync.sv
module ebus_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ebus_ack_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ebus_wait_cnt.sv
module ebus_wait_cnt #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [WAIT_W-1:0] limit_i,
   output logic              reached_o
);
   generate
      if (WAIT_W < 1) begin : g_bad_width
         $error("ebus_wait_cnt: WAIT_W must be at least 1");
      end
   endgenerate

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= WAIT_W'(1);
      end else if (step_i && (cnt_q < limit_i)) begin
         cnt_q <= cnt_q + WAIT_W'(1);
      end
   end

   assign reached_o = (cnt_q >= limit_i);

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !load_i && (limit_i != '0) |=> (cnt_q <= $past(limit_i)) || load_i);
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [WAIT_W-1:0] min_wait_i,
   input  logic              master_i,
   input  logic              ack_ok_i,
   input  logic              reached_i,
   input  logic [DATA_W-1:0] rdata_i,
   output ebus_state_t       state_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [WAIT_W-1:0] min_wait_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              load_o,
   output logic              step_o
);
   ebus_state_t       state_q;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [WAIT_W-1:0] mw_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         mw_q    <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == ST_FINISH);
         case (state_q)
            ST_IDLE: begin
               if (req_i && master_i && !done_q) begin
                  we_q    <= we_i;
                  addr_q  <= addr_i;
                  wdata_q <= wdata_i;
                  mw_q    <= min_wait_i;
                  state_q <= ST_ASSERT;
               end
            end
            ST_ASSERT: begin
               state_q <= (mw_q == '0) ? ST_FINISH : ST_WAIT;
            end
            ST_WAIT: begin
               if (reached_i && ack_ok_i) state_q <= ST_FINISH;
            end
            ST_FINISH: begin
               if (!we_q) rdata_q <= rdata_i;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o    = state_q;
   assign we_o       = we_q;
   assign addr_o     = addr_q;
   assign wdata_o    = wdata_q;
   assign min_wait_o = mw_q;
   assign rdata_o    = rdata_q;
   assign done_o     = done_q;
   assign load_o     = (state_q == ST_ASSERT);
   assign step_o     = (state_q == ST_WAIT);

   assert_zero_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ASSERT) && (mw_q == '0) |=> (state_q == ST_FINISH));

   assert_min_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) && !reached_i |=> (state_q == ST_WAIT));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (state_q == ST_IDLE));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) && !master_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
   import ebus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 24,
   parameter int WAIT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [WAIT_W-1:0] min_wait_i,
   input  logic              master_i,
   input  logic              ack_i,
   input  logic              ack_async_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              addr_oe_o,
   output logic              data_oe_o,
   output logic              strobe_oe_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("ebus_wait_ctrl: bus widths must be positive");
      end
      if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
         $error("ebus_wait_ctrl: WAIT_W out of range");
      end
   endgenerate

   ebus_state_t       state;
   logic              we_q;
   logic [WAIT_W-1:0] mw_q;
   logic              load;
   logic              step;
   logic              reached;
   logic              ack_synced;
   logic              ack_ok;
   logic              live_q;
   logic              active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   ebus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ack_i),
      .q_o   (ack_synced)
   );

   assign ack_ok = master_i & (ack_async_i ? ack_synced : ack_i);

   ebus_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .step_i    (step),
      .limit_i   (mw_q),
      .reached_o (reached)
   );

   ebus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .we_i       (we_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .min_wait_i (min_wait_i),
      .master_i   (master_i),
      .ack_ok_i   (ack_ok),
      .reached_i  (reached),
      .rdata_i    (rdata_i),
      .state_o    (state),
      .we_o       (we_q),
      .addr_o     (addr_o),
      .wdata_o    (wdata_o),
      .min_wait_o (mw_q),
      .rdata_o    (rdata_o),
      .done_o     (done_o),
      .load_o     (load),
      .step_o     (step)
   );

   assign active      = (state != ST_IDLE);
   assign rd_n_o      = !(active && !we_q);
   assign wr_n_o      = !(active && we_q);
   assign addr_oe_o   = master_i && live_q;
   assign strobe_oe_o = master_i && live_q;
   assign data_oe_o   = master_i && live_q && active && we_q;

   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n_o && wr_n_o && !req_i |=> rd_n_o && wr_n_o);
endmodule

// File: tb/tb_ebus_wait_ctrl.sv
module tb_ebus_wait_ctrl;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int WW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0, we_i = 1'b0, master_i = 1'b1, ack_i = 1'b0, ack_async_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] wdata_i = '0, rdata_i = '0;
   logic [WW-1:0] min_wait_i = '0;
   logic rd_n_o, wr_n_o, addr_oe_o, data_oe_o, strobe_oe_o, done_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] wdata_o, rdata_o;

   int total = 0, bad = 0;
   int lowcnt = 0;
   int ack_at = 0;
   bit ack_en = 1'b0, ack_force = 1'b0;

   always #4 clk = ~clk;

   ebus_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .min_wait_i(min_wait_i), .master_i(master_i), .ack_i(ack_i),
      .ack_async_i(ack_async_i), .rdata_i(rdata_i), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
      .addr_o(addr_o), .wdata_o(wdata_o), .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o),
      .strobe_oe_o(strobe_oe_o), .rdata_o(rdata_o), .done_o(done_o));

   always @(negedge clk) begin
      if (!rd_n_o || !wr_n_o) lowcnt = lowcnt + 1;
      else lowcnt = 0;
      ack_i = ack_force | (ack_en && (lowcnt >= ack_at));
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int exp_len(input int n, input int a, input bit as);
      if (n == 0) return 2;
      if (!as) return 2 + imax(n, a - 1);
      if (a == 0) return 2 + n;
      return 2 + imax(n, a + 1);
   endfunction

   task automatic xfer(input int n, input int a, input bit as, input bit we, input int seq);
      int len = 0, guard = 0;
      bit strobe_ok = 1'b1, addr_ok = 1'b1, doe_ok = 1'b1, wd_ok = 1'b1;
      logic [AW-1:0] ad = AW'(seq * 37 + 5);
      logic [DW-1:0] wd = DW'(seq * 11 + 3);
      logic [DW-1:0] rd = DW'(seq * 29 + 17);
      string tag = (n == 0) ? "R4" : (as ? "R6" : "R5");
      @(negedge clk);
      min_wait_i = WW'(n); ack_at = a; ack_async_i = as; we_i = we;
      addr_i = ad; wdata_i = wd; rdata_i = rd; ack_en = 1'b1; req_i = 1'b1;
      do begin @(negedge clk); guard++; end while (rd_n_o && wr_n_o && guard < 20);
      req_i = 1'b0;
      while ((!rd_n_o || !wr_n_o) && len < 40) begin
         len++;
         if (we ? (wr_n_o || !rd_n_o) : (rd_n_o || !wr_n_o)) strobe_ok = 1'b0;
         if (addr_o != ad || !addr_oe_o) addr_ok = 1'b0;
         if (data_oe_o != we) doe_ok = 1'b0;
         if (we && wdata_o != wd) wd_ok = 1'b0;
         @(negedge clk);
      end
      chk(len == exp_len(n, a, as), tag, len, exp_len(n, a, as));
      chk(strobe_ok, "R3 strobe", int'(strobe_ok), 1);
      chk(doe_ok && wd_ok, "R3 data", int'(doe_ok && wd_ok), 1);
      chk(addr_ok, "R9", int'(addr_ok), 1);
      chk(done_o == 1'b1, "R7 done", int'(done_o), 1);
      if (!we) chk(rdata_o == rd, "R7 rdata", int'(rdata_o), int'(rd));
      @(negedge clk);
      chk(done_o == 1'b0, "R7 pulse", int'(done_o), 0);
      ack_en = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seq = 0;
      int gap = 0;
      int wt = 0;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!addr_oe_o && !data_oe_o && !strobe_oe_o, "R1 oe", int'(addr_oe_o|data_oe_o|strobe_oe_o), 0);
      chk(rd_n_o && wr_n_o, "R1 strobes", int'(rd_n_o & wr_n_o), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(addr_oe_o && strobe_oe_o, "R2 oe master", int'(addr_oe_o & strobe_oe_o), 1);

      // R8: acknowledge with no request
      ack_force = 1'b1;
      repeat (10) begin
         @(negedge clk);
         chk(rd_n_o && wr_n_o && !done_o, "R8", int'(rd_n_o & wr_n_o & !done_o), 1);
      end
      ack_force = 1'b0;
      repeat (3) @(negedge clk);

      // main sweep: R3 R4 R5 R6 R7 R9
      for (int as = 0; as < 2; as++)
         for (int we = 0; we < 2; we++)
            for (int n = 0; n < 6; n++)
               for (int a = 0; a < 8; a++) begin
                  xfer(n, a, bit'(as), bit'(we), seq);
                  seq++;
                  repeat (2) @(negedge clk);
               end

      // R2: request held while not master
      master_i = 1'b0; ack_async_i = 1'b0; min_wait_i = WW'(1);
      ack_en = 1'b1; ack_at = 0; we_i = 1'b0; req_i = 1'b1;
      repeat (6) begin
         @(negedge clk);
         chk(!addr_oe_o && !data_oe_o && !strobe_oe_o && rd_n_o && wr_n_o,
             "R2 held", int'(addr_oe_o|data_oe_o|strobe_oe_o|!rd_n_o), 0);
      end
      master_i = 1'b1;
      @(negedge clk);
      chk(!rd_n_o, "R2 start", int'(rd_n_o), 0);
      req_i = 1'b0;
      wt = 0;
      while (!done_o && wt < 20) begin @(negedge clk); wt++; end
      repeat (3) @(negedge clk);

      // R10: back-to-back with request held
      min_wait_i = WW'(1); ack_at = 0; we_i = 1'b1; req_i = 1'b1;
      wt = 0;
      while (wr_n_o && wt < 20) begin @(negedge clk); wt++; end
      wt = 0;
      while (!wr_n_o && wt < 20) begin @(negedge clk); wt++; end
      gap = 0;
      while (wr_n_o && gap < 20) begin @(negedge clk); gap++; end
      chk(gap == 2, "R10 gap", gap, 2);
      req_i = 1'b0;
      repeat (10) @(negedge clk);
      ack_en = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule